// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that software reaches through an 8-bit register bus. The counter can follow an internal tick, which fires once every four system clocks. It can also follow rising edges on an external clock pin. A divider selects a ratio of 1, 2, 4 or 8 and sits between the chosen source and the counter. An external edge can pass through a two-flop synchronizer, or it can take a shorter path that has no synchronizer.

A sticky flag marks each wrap from all-ones to zero, and the flag also drives the interrupt output. A single-cycle event input from a compare unit clears the count. Software moves the 16-bit value one byte at a time. In the buffered-wide mode the upper byte goes through a holding register, so that software reads and writes all 16 bits as one consistent value.

The register addresses are as follows: 0 is control, 1 is the count low byte, 2 is the count high byte, and 3 is status. The control byte has these fields: bit 0 = run, bit 1 = external source select, bit 2 = synchronizer bypass, bits 4:3 = divider code, bit 5 = buffered-wide mode. Status bit 0 holds the wrap flag.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the control byte, the count, the wrap flag, the holding byte and the read data output are all zero.
- R2: When run=1 and source select=0, the count advances once each time a divide-by-4 phase completes. That phase starts at zero on reset, so a tick lands on every fourth clock edge after reset, subject to the divider.
- R3: The divider code in control bits 4:3 selects a ratio of 2^code (codes 0 to 3 give 1, 2, 4 and 8). Writing either count byte clears the partial divider count.
- R4: When source select=1 and bypass=0, each rising edge of the external input gives exactly one divider tick, after passing through a two-flop synchronizer.
- R5: When source select=1 and bypass=1, an external rising edge present at a clock edge is counted at that same edge, with no synchronizer delay.
- R6: While run=0 the count holds its value.
- R7: A wrap from 0xFFFF to 0x0000 sets the wrap flag (status bit 0, also ovf_irq_o). The flag stays set, and when a set and a clear fall in the same cycle, the set wins.
- R8: Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged.
- R9: A pulse on evt_clr_i clears the count. It takes priority over a bus write and over an increment in the same cycle.
- R10: When a count write and an increment fall in the same cycle, the written value is stored.
- R11: In buffered-wide mode (bit 5 = 1), a write to the high address fills only the holding byte. A write to the low address loads {holding byte, data}. A read of the low address copies the live high byte into the holding byte. A read of the high address returns the holding byte.
- R12: In direct mode (bit 5 = 0), the high byte is read and written live at its own address.
- R13: Read data appears on bus_rdata_o on the cycle after bus_rd_i and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External count clock |
| evt_clr_i | input | 1 | Special-event clear of the count |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| ovf_irq_o | output | 1 | Wrap flag / interrupt |

## Verification
The bench sweeps every divider code over several whole tick counts in both internal and external modes. A divider that used the wrong ratio, or that kept a stale remainder after a count write, would give a final value that is off. It lines a bus write and an event clear up with a known internal tick edge. A design with the wrong priority there would store the written value plus one, or keep the written value instead of zero. It counts a single external edge that coincides with a disabling write. Only the bypass path can count that edge, so swapped paths would show up as 0 versus 1. It steps the counter through 0xFFFF, clears the flag with both data values, and drives the holding-byte sequences of the wide mode. A design that wrote the high byte live in that mode would expose the new byte on the next read.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int PS_W = 2;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CNT_LO = 2'd1,
    A_CNT_HI = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;

  // Packed MSB first: wide is bit 5, run is bit 0.
  typedef struct packed {
    logic            wide;
    logic [PS_W-1:0] ps;
    logic            byp;
    logic            ext_sel;
    logic            run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ptmr_src.sv
module ptmr_src #(
  parameter int INSTR_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk_i,
  input  logic run_i,
  input  logic ext_sel_i,
  input  logic byp_i,
  output logic tick_o
);
  localparam int PH_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;

  logic [PH_W-1:0]      phase_q;
  logic                 instr_tick;
  logic [SYNC_STAGES:0] sync_q;
  logic                 sync_rise;
  logic                 raw_q;
  logic                 raw_rise;

  assign instr_tick = (phase_q == PH_W'(INSTR_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (instr_tick) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  // Synchronizer chain plus one extra stage for edge detection.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end
  assign sync_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // Bypass path: edge taken straight from the pin.
  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else raw_q <= ext_clk_i;
  end
  assign raw_rise = ext_clk_i & ~raw_q;

  always_comb begin
    if (!run_i) tick_o = 1'b0;
    else if (!ext_sel_i) tick_o = instr_tick;
    else if (byp_i) tick_o = raw_rise;
    else tick_o = sync_rise;
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            clr_i,
  output logic            tick_o
);
  localparam int CW = (1 << PS_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          last;

  assign lim    = CW'((32'd1 << ps_i) - 32'd1);
  assign last   = (cnt_q == lim);
  assign tick_o = tick_i & last;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             evt_clr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic wrap;

  assign wrap = inc_i & ~load_i & ~evt_clr_i & (&cnt_o);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else if (evt_clr_i) cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_o <= 1'b0;
    else if (wrap) ovf_o <= 1'b1;
    else if (flag_clr_i) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/ptmr_regif.sv
module ptmr_regif
  import ptmr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [2*BUS_W-1:0] cnt_i,
  input  logic               ovf_i,
  output ctrl_t              ctrl_o,
  output logic               load_o,
  output logic [2*BUS_W-1:0] load_val_o,
  output logic               flag_clr_o,
  output logic               ps_clr_o,
  output logic [BUS_W-1:0]   rdata_o
);
  reg_addr_e        addr;
  logic [BUS_W-1:0] hbuf_q;
  logic [BUS_W-1:0] cnt_lo;
  logic [BUS_W-1:0] cnt_hi;
  logic             wr_lo;
  logic             wr_hi;

  assign addr   = reg_addr_e'(addr_i);
  assign cnt_lo = cnt_i[BUS_W-1:0];
  assign cnt_hi = cnt_i[2*BUS_W-1:BUS_W];
  assign wr_lo  = wr_i & (addr == A_CNT_LO);
  assign wr_hi  = wr_i & (addr == A_CNT_HI);

  assign ps_clr_o   = wr_lo | wr_hi;
  assign flag_clr_o = wr_i & (addr == A_STAT) & ~wdata_i[0];

  always_comb begin
    load_o     = 1'b0;
    load_val_o = cnt_i;
    if (wr_lo) begin
      load_o     = 1'b1;
      load_val_o = {(ctrl_o.wide ? hbuf_q : cnt_hi), wdata_i};
    end else if (wr_hi && !ctrl_o.wide) begin
      load_o     = 1'b1;
      load_val_o = {wdata_i, cnt_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o  <= '0;
      hbuf_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i && addr == A_CTRL) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_hi && ctrl_o.wide) hbuf_q <= wdata_i;
      if (rd_i) begin
        unique case (addr)
          A_CTRL:   rdata_o <= BUS_W'(ctrl_o);
          A_CNT_LO: begin
            rdata_o <= cnt_lo;
            if (ctrl_o.wide) hbuf_q <= cnt_hi;
          end
          A_CNT_HI: rdata_o <= ctrl_o.wide ? hbuf_q : cnt_hi;
          A_STAT:   rdata_o <= BUS_W'(ovf_i);
          default:  rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
  import ptmr_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int INSTR_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk_i,
  input  logic             evt_clr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             ovf_irq_o
);
  localparam int CNT_W = 2 * BUS_W;

  ctrl_t            ctrl_q;
  logic             run_en;
  logic             src_tick;
  logic             pre_tick;
  logic             ps_clr;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic             flag_clr;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign run_en    = ctrl_q.run;
  assign ovf_irq_o = ovf_q;

  ptmr_src #(.INSTR_DIV(INSTR_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .run_i(run_en),
    .ext_sel_i(ctrl_q.ext_sel), .byp_i(ctrl_q.byp), .tick_o(src_tick)
  );

  ptmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(src_tick), .ps_i(ctrl_q.ps),
    .clr_i(ps_clr), .tick_o(pre_tick)
  );

  ptmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc_i(pre_tick), .load_i(load_en),
    .load_val_i(load_val), .evt_clr_i(evt_clr_i), .flag_clr_i(flag_clr),
    .cnt_o(cnt_q), .ovf_o(ovf_q)
  );

  ptmr_regif #(.BUS_W(BUS_W)) u_reg (
    .clk(clk), .rst(rst), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .cnt_i(cnt_q), .ovf_i(ovf_q),
    .ctrl_o(ctrl_q), .load_o(load_en), .load_val_o(load_val),
    .flag_clr_o(flag_clr), .ps_clr_o(ps_clr), .rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/prescaled_timer16_chk.sv
module prescaled_timer16_chk #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             inc,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic             evt,
  input logic             run,
  input logic             flag_clr,
  input logic             rd,
  input logic [BUS_W-1:0] rdata
);
  assert_evt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    evt |=> cnt == '0);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    load && !evt |=> cnt == $past(load_val));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    inc && !load && !evt |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !run && !load && !evt |=> $stable(cnt));

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    inc && !load && !evt && (&cnt) |=> ovf);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf && !flag_clr |=> ovf);

  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !(inc && !load && !evt && (&cnt)) |=> !ovf);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

bind prescaled_timer16 prescaled_timer16_chk #(.CNT_W(2*BUS_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .ovf(ovf_q), .inc(pre_tick),
  .load(load_en), .load_val(load_val), .evt(evt_clr_i), .run(run_en),
  .flag_clr(flag_clr), .rd(bus_rd_i), .rdata(bus_rdata_o)
);

// File: tb/prescaled_timer16_tb.sv
module prescaled_timer16_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk_i = 1'b0;
  logic       evt_clr_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       ovf_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int tcyc = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tcyc <= 0;
    else tcyc <= tcyc + 1;
  end

  prescaled_timer16 u_dut (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .evt_clr_i(evt_clr_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ctrl byte: bit0 run, bit1 ext, bit2 bypass, bits4:3 divider, bit5 wide
  function automatic logic [7:0] cb(input bit run, input bit ext, input bit byp,
                                    input int ps, input bit wide);
    return {2'b00, wide, 2'(ps), byp, ext, run};
  endfunction

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_i = 1'b1; wait_n(2);
      ext_clk_i = 1'b0; wait_n(2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", {8'h0, bus_rdata_o}, 16'h0);
    chk("R1 irq", {15'h0, ovf_irq_o}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv); chk("R1 reg", {8'h0, rv}, 16'h0);
    end

    // R2/R3 internal source over every divider code
    for (int ps = 0; ps < 4; ps++) begin
      for (int k = 1; k <= 3; k++) begin
        wr(2'd0, cb(0, 0, 0, ps, 0));
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, cb(1, 0, 0, ps, 0));
        wait_n(4 * (1 << ps) * k - 1);
        wr(2'd0, cb(0, 0, 0, ps, 0));
        rd(2'd1, rv); chk("R2 R3 internal count", {8'h0, rv}, 16'(k));
      end
    end

    // R3 partial remainder then clearing by a count write
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    wr(2'd0, cb(1, 0, 0, 2, 0));
    wait_n(43);
    wr(2'd0, cb(0, 0, 0, 2, 0));
    rd(2'd1, rv); chk("R3 remainder", {8'h0, rv}, 16'h2);
    wr(2'd1, 8'h00);
    wr(2'd0, cb(1, 0, 0, 2, 0));
    wait_n(11);
    wr(2'd0, cb(0, 0, 0, 2, 0));
    rd(2'd1, rv); chk("R3 divider cleared by write", {8'h0, rv}, 16'h0);

    // R13 control readback
    rd(2'd0, rv); chk("R13 ctrl readback", {8'h0, rv}, {8'h0, cb(0, 0, 0, 2, 0)});

    // R4/R5 external source, both paths, every divider code
    for (int byp = 0; byp < 2; byp++) begin
      for (int ps = 0; ps < 4; ps++) begin
        wr(2'd0, cb(0, 1, byp[0], ps, 0));
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, cb(1, 1, byp[0], ps, 0));
        pulse_ext(13);
        wait_n(6);
        wr(2'd0, cb(0, 1, byp[0], ps, 0));
        rd(2'd1, rv);
        chk(byp ? "R5 bypass count" : "R4 sync count", {8'h0, rv}, 16'(13 >> ps));
      end
    end

    // R4/R5 latency: edge arriving with the disabling write
    for (int byp = 0; byp < 2; byp++) begin
      wr(2'd0, cb(0, 1, byp[0], 0, 0));
      wr(2'd1, 8'h00);
      wr(2'd0, cb(1, 1, byp[0], 0, 0));
      wait_n(3);
      ext_clk_i = 1'b1;
      wr(2'd0, cb(0, 1, byp[0], 0, 0));
      wait_n(4);
      ext_clk_i = 1'b0;
      wait_n(4);
      rd(2'd1, rv);
      chk(byp ? "R5 same-edge count" : "R4 synchronizer delay", {8'h0, rv}, byp ? 16'h1 : 16'h0);
    end

    // R6 hold while stopped
    wr(2'd1, 8'h5A);
    wait_n(40);
    rd(2'd1, rv); chk("R6 hold", {8'h0, rv}, 16'h5A);

    // R7/R8 wrap flag
    wr(2'd0, cb(0, 0, 0, 0, 0));
    wr(2'd2, 8'hFF); wr(2'd1, 8'hFE);
    wr(2'd0, cb(1, 0, 0, 0, 0));
    wait_n(3);
    wr(2'd0, cb(0, 0, 0, 0, 0));
    rd(2'd3, rv); chk("R7 no flag at FFFF", {8'h0, rv}, 16'h0);
    rd(2'd2, rv); chk("R7 high at FFFF", {8'h0, rv}, 16'hFF);
    wr(2'd0, cb(1, 0, 0, 0, 0));
    wait_n(3);
    wr(2'd0, cb(0, 0, 0, 0, 0));
    rd(2'd1, rv); chk("R7 wrapped low", {8'h0, rv}, 16'h0);
    rd(2'd2, rv); chk("R7 wrapped high", {8'h0, rv}, 16'h0);
    rd(2'd3, rv); chk("R7 flag set", {8'h0, rv}, 16'h1);
    chk("R7 irq", {15'h0, ovf_irq_o}, 16'h1);
    wait_n(10);
    chk("R7 sticky", {15'h0, ovf_irq_o}, 16'h1);
    wr(2'd3, 8'h01);
    rd(2'd3, rv); chk("R8 write one keeps flag", {8'h0, rv}, 16'h1);
    wr(2'd3, 8'h00);
    rd(2'd3, rv); chk("R8 write zero clears", {8'h0, rv}, 16'h0);
    chk("R8 irq low", {15'h0, ovf_irq_o}, 16'h0);

    // R9 event clear, alone and against a write
    wr(2'd2, 8'h12); wr(2'd1, 8'h34);
    evt_clr_i = 1'b1; wait_n(1); evt_clr_i = 1'b0;
    rd(2'd1, rv); chk("R9 clear low", {8'h0, rv}, 16'h0);
    rd(2'd2, rv); chk("R9 clear high", {8'h0, rv}, 16'h0);
    wr(2'd2, 8'h12);
    evt_clr_i = 1'b1; wr(2'd1, 8'h55); evt_clr_i = 1'b0;
    rd(2'd1, rv); chk("R9 beats write low", {8'h0, rv}, 16'h0);
    rd(2'd2, rv); chk("R9 beats write high", {8'h0, rv}, 16'h0);

    // R10 write on a tick edge; R9 clear on a tick edge
    wr(2'd0, cb(1, 0, 0, 0, 0));
    while (tcyc % 4 != 3) @(negedge clk);
    wr(2'd1, 8'h40);
    wr(2'd0, cb(0, 0, 0, 0, 0));
    rd(2'd1, rv); chk("R10 write beats increment", {8'h0, rv}, 16'h40);
    wr(2'd0, cb(1, 0, 0, 0, 0));
    while (tcyc % 4 != 3) @(negedge clk);
    evt_clr_i = 1'b1; wait_n(1); evt_clr_i = 1'b0;
    wr(2'd0, cb(0, 0, 0, 0, 0));
    rd(2'd1, rv); chk("R9 beats increment", {8'h0, rv}, 16'h0);

    // R11 buffered-wide mode
    wr(2'd0, cb(0, 0, 0, 0, 1));
    wr(2'd2, 8'h34); wr(2'd1, 8'h56);
    rd(2'd1, rv); chk("R11 wide low", {8'h0, rv}, 16'h56);
    rd(2'd2, rv); chk("R11 wide high", {8'h0, rv}, 16'h34);
    evt_clr_i = 1'b1; wait_n(1); evt_clr_i = 1'b0;
    rd(2'd2, rv); chk("R11 holding byte kept", {8'h0, rv}, 16'h34);
    rd(2'd1, rv); chk("R11 live low", {8'h0, rv}, 16'h0);
    rd(2'd2, rv); chk("R11 latched high", {8'h0, rv}, 16'h0);
    wr(2'd2, 8'h77);
    rd(2'd1, rv);
    rd(2'd2, rv); chk("R11 high write buffered only", {8'h0, rv}, 16'h0);

    // R12 direct mode
    wr(2'd0, cb(0, 0, 0, 0, 0));
    wr(2'd2, 8'h9A);
    rd(2'd2, rv); chk("R12 direct high", {8'h0, rv}, 16'h9A);
    rd(2'd1, rv); chk("R12 low untouched", {8'h0, rv}, 16'h0);

    // R13 read data holds between reads
    wr(2'd1, 8'h21);
    wait_n(3);
    chk("R13 rdata held", {8'h0, bus_rdata_o}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule